// File: doc/BRIEF.md
# Peripheral Quadrant Write-Protection Controller

This block keeps one write-protection bit for every quadrant of every peripheral select: four quadrants for each of 32 selects, 128 bits in all. Software reaches the bits through two aliases of each 32-bit protection word. One alias is write-one-to-set and the other is write-one-to-clear, and both read back the same stored value. Only a privileged register write can change a bit. Reads are open to every mode.

The same bits gate a peripheral access path. A write from user mode to a protected quadrant is refused and raises a one-cycle violation flag. Reads in either mode are always let through, and so are privileged writes. The `IMPL_MASK` parameter lists the bit positions that have a real slave behind them. The other positions are absent: they keep no state and read as zero.

Top module: `quad_wprot`

## Requirements
- R1: After reset every protection bit is 0, so all eight alias words read 0.
- R2: The set aliases are at byte offsets 0x20, 0x24, 0x28 and 0x2C, and the clear aliases at 0x40, 0x44, 0x48 and 0x4C. Word k covers peripheral selects 8k to 8k+7. Inside the word, the bit for select p and quadrant q sits at position 4*(p mod 8)+q. Any other offset reads 0 and ignores writes.
- R3: A privileged write of 1 to a bit of a set alias makes that protection bit 1. After the write, the set alias and the clear alias both read 1 at that position.
- R4: A privileged write of 1 to a bit of a clear alias makes that protection bit 0. After the write, both aliases read 0 at that position.
- R5: A 0 in the write data of either alias leaves the matching protection bit unchanged.
- R6: A register write with reg_priv low changes no protection bit. Register reads return the same data whatever the value of reg_priv.
- R7: A bit position whose `IMPL_MASK` bit is 0 always reads 0 and ignores set writes.
- R8: acc_grant is high, in the same cycle, for any valid read, any valid privileged write and any valid user write to a quadrant whose bit is 0. It is low for a user write to a quadrant whose bit is 1, and low whenever acc_valid is low.
- R9: acc_violation is high for exactly the one cycle that follows each refused access, and low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Register access is a write |
| reg_priv | input | 1 | Register access is privileged |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Peripheral access request |
| acc_wr | input | 1 | Peripheral access is a write |
| acc_priv | input | 1 | Peripheral access is privileged |
| acc_ps | input | PS_W | Peripheral select of the access |
| acc_quad | input | 2 | Quadrant of the access |
| acc_grant | output | 1 | Access allowed |
| acc_violation | output | 1 | One-cycle pulse after a refused access |

## Verification
Each alias word is driven with an alternating pattern, an all-ones word and a nibble-striped clear. These show whether set, clear and keep act on the right bits. They also catch swapped aliases and a shifted word index. The same words are then written without privilege and at unmapped offsets, which separates a correct privilege gate from a decode leak. Finally, all 128 quadrants are swept with every mix of read or write and user or privileged. This sweep pins down the bit order within a word and the timing of the violation pulse. The bench's mask leaves out two nibbles in different words to show that absent positions never hold state.

// File: rtl/quad_wprot.sv
module quad_wprot #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] SET_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] CLR_BASE = 8'h40,
  parameter logic [32*NUM_REGS-1:0] IMPL_MASK = '1,
  localparam int NBITS = 32*NUM_REGS,
  localparam int NPS   = NBITS/4,
  localparam int PS_W  = (NPS > 1) ? $clog2(NPS) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_priv,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic              acc_priv,
  input  logic [PS_W-1:0]   acc_ps,
  input  logic [1:0]        acc_quad,
  output logic              acc_grant,
  output logic              acc_violation
);

  logic [NBITS-1:0]  prot_q, set_vec, clr_vec;
  logic [ADDR_W-1:0] set_off, clr_off;
  logic              set_hit, clr_hit, wr_ok, blocked;
  logic [IDX_W-1:0]  set_idx, clr_idx;

  assign set_off = reg_addr - SET_BASE;
  assign clr_off = reg_addr - CLR_BASE;
  assign set_hit = reg_sel && (set_off[1:0] == 2'b00) && ((set_off >> 2) < ADDR_W'(NUM_REGS));
  assign clr_hit = reg_sel && (clr_off[1:0] == 2'b00) && ((clr_off >> 2) < ADDR_W'(NUM_REGS));
  assign set_idx = set_off[IDX_W+1:2];
  assign clr_idx = clr_off[IDX_W+1:2];
  assign wr_ok   = reg_wr && reg_priv;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (wr_ok && set_hit) set_vec[32*int'(set_idx) +: 32] = reg_wdata;
    if (wr_ok && clr_hit) clr_vec[32*int'(clr_idx) +: 32] = reg_wdata;
    set_vec = set_vec & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prot_q <= '0;
    else        prot_q <= (prot_q | set_vec) & ~clr_vec;
  end

  always_comb begin
    reg_rdata = '0;
    if (set_hit)      reg_rdata = prot_q[32*int'(set_idx) +: 32];
    else if (clr_hit) reg_rdata = prot_q[32*int'(clr_idx) +: 32];
  end

  assign blocked   = acc_valid && acc_wr && !acc_priv && prot_q[{acc_ps, acc_quad}];
  assign acc_grant = acc_valid && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_violation <= 1'b0;
    else        acc_violation <= blocked;
  end

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((prot_q & $past(set_vec)) == $past(set_vec)));

  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((prot_q & $past(clr_vec)) == '0));

  // R6
  user_reg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && !reg_priv) |=> $stable(prot_q));

  // R7
  absent_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((prot_q & ~IMPL_MASK) == '0));

  // R8
  grant_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (!acc_wr || acc_priv)) |-> acc_grant);

  // R9
  violation_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_violation |-> $past(acc_valid && !acc_grant));

endmodule

// File: tb/test_quad_wprot.sv
`timescale 1ns/1ps
module test_quad_wprot;
  localparam logic [127:0] MASK = 128'hF0FF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF0F;

  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_wr = 0, reg_priv = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic acc_valid = 0, acc_wr = 0, acc_priv = 0;
  logic [4:0] acc_ps = 0;
  logic [1:0] acc_quad = 0;
  logic acc_grant, acc_violation;
  logic [127:0] model = '0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  quad_wprot #(.IMPL_MASK(MASK)) i_quad_wprot (
    .clk, .rst_n, .reg_sel, .reg_wr, .reg_priv, .reg_addr, .reg_wdata, .reg_rdata,
    .acc_valid, .acc_wr, .acc_priv, .acc_ps, .acc_quad, .acc_grant, .acc_violation);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic p);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_priv = p; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd_both(string req, int k, logic p);
    logic [31:0] e = model[32*k +: 32];
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_priv = p; reg_addr = 8'h20 + 8'(4*k);
    #1 check(req, reg_rdata, e);
    reg_addr = 8'h40 + 8'(4*k);
    #1 check(req, reg_rdata, e);
    reg_sel = 0;
  endtask

  task automatic set_p(int k, logic [31:0] d);
    wr(8'h20 + 8'(4*k), d, 1);
    model[32*k +: 32] = model[32*k +: 32] | (d & MASK[32*k +: 32]);
  endtask

  task automatic clr_p(int k, logic [31:0] d);
    wr(8'h40 + 8'(4*k), d, 1);
    model[32*k +: 32] = model[32*k +: 32] & ~d;
  endtask

  task automatic sweep();
    for (int b = 0; b < 128; b++) begin
      for (int m = 0; m < 4; m++) begin
        logic w = m[0], p = m[1];
        logic blk = w && !p && model[b];
        @(negedge clk);
        acc_valid = 1; acc_wr = w; acc_priv = p;
        acc_ps = 5'(b / 4); acc_quad = 2'(b % 4);
        #1 check("R8", {31'd0, acc_grant}, {31'd0, !blk});
        @(posedge clk); #1;
        check("R9", {31'd0, acc_violation}, {31'd0, blk});
        acc_valid = 0;
      end
    end
    @(posedge clk); #1;
    check("R9", {31'd0, acc_violation}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int k = 0; k < 4; k++) rd_both("R1", k, 1);
    @(negedge clk);
    check("R8", {31'd0, acc_grant}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      set_p(k, 32'hA5A5_A5A5 ^ (32'h1 << k));
      rd_both("R3", k, 1);
      set_p(k, 32'h0000_0000);
      rd_both("R5", k, 0);
    end
    sweep();
    for (int k = 0; k < 4; k++) begin
      wr(8'h20 + 8'(4*k), 32'hFFFF_FFFF, 0);
      rd_both("R6", k, 0);
    end
    for (int k = 0; k < 4; k++) begin
      set_p(k, 32'hFFFF_FFFF);
      rd_both("R7", k, 1);
      clr_p(k, 32'h0F0F_0F0F << k);
      rd_both("R4", k, 0);
      wr(8'h40 + 8'(4*k), 32'hFFFF_FFFF, 0);
      rd_both("R6", k, 1);
    end
    wr(8'h30, 32'hFFFF_FFFF, 1);
    wr(8'h24 + 8'h1, 32'hFFFF_FFFF, 1);
    wr(8'h50, 32'hFFFF_FFFF, 1);
    for (int k = 0; k < 4; k++) rd_both("R2", k, 1);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = 8'h30;
    #1 check("R2", reg_rdata, 32'd0);
    reg_addr = 8'h1C;
    #1 check("R2", reg_rdata, 32'd0);
    reg_sel = 0;
    sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule